// File: doc/BRIEF.md
# Width-Adapting Register Bridge

This block joins a host port that issues byte, 16-bit word and 32-bit long accesses to a register file in which every register has one fixed native width of one, two or four bytes. The native width is not carried by the host. The bridge finds it in a parameter map that holds one entry per aligned 4-byte group of the register offset space. From that entry it rewrites each host access into a short run of native-width accesses on a single register-side port, in big-endian byte order.

There are three cases. A host access wider than the native width is split into consecutive native accesses, with the most significant part first. A narrower read fetches the containing register and extracts the requested bytes. A narrower write fetches the register, merges in the new bytes and writes the whole register back.

A sequencer drives the register port. Its states are `ST_IDLE`, `ST_SPLIT`, `ST_FETCH`, `ST_MERGE` and `ST_FINISH`. Its transitions are:

- `ST_IDLE` to `ST_FINISH` for an out-of-range offset or unmapped space.
- `ST_IDLE` to `ST_FETCH` when the access is narrower than the register.
- `ST_IDLE` to `ST_SPLIT` when the access is as wide as the register or wider.
- `ST_SPLIT` loops on itself until the last piece, then goes to `ST_FINISH`.
- `ST_FETCH` goes to `ST_MERGE` for a write, or to `ST_FINISH` for a read.
- `ST_MERGE` goes to `ST_FINISH`.
- `ST_FINISH` goes to `ST_IDLE`.

The host sees completion as a one-cycle done pulse.

Top module: `regbus_width_bridge`

## Requirements
- R1: While reset is held and in the first cycle after it, host_done, host_err and reg_en are low.
- R2: The register offset is the low ADDR_W (default 10) bits of host_addr. An aligned offset above LIMIT (default 0x200) completes with host_err=1 and host_rdata=0 in the cycle after the request, with no register-side cycle. Offset 0x200 itself is legal.
- R3: The native width is taken from WMAP, 2 bits per group, at bit position 2*offset[ADDR_W-1:2]. The codes are 0 = unmapped, 1 = byte, 2 = word, 3 = long.
- R4: An access to an unmapped group makes no register-side cycle. It completes in the next cycle with host_err=0 and host_rdata=0, so its writes are dropped.
- R5: host_size codes are 0 = byte, 1 = word, 2 or 3 = long. Data is right-aligned on both sides. An access as wide as its register makes exactly one register access at the offset.
- R6: A read narrower than its register does one read at the register's aligned address. It returns the bytes at position offset mod native-width, where position 0 is the most significant byte.
- R7: A write narrower than its register reads the register, then writes it back at the same address with only the addressed bytes replaced, big-endian, in the next cycle.
- R8: A word access to a byte register becomes two byte accesses. Host bits 15:8 go to the offset and bits 7:0 go to offset+1.
- R9: A long access to narrower registers becomes consecutive native accesses, most significant part first, at ascending addresses. That is two word accesses (offset, offset+2) or four byte accesses (offset to offset+3).
- R10: Register accesses occur on consecutive cycles starting in the cycle after the request. host_done is a one-cycle pulse in the cycle after the last of them, and there are never more than four per host access.
- R11: The low host_addr bits below the access size are ignored. A word access clears bit 0, and a long access clears bits 1:0.
- R12: host_req is accepted only in ST_IDLE. A request held or changed while an access is in progress starts no access and changes none.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Request, sampled in the idle state |
| host_we | input | 1 | 1 = write, 0 = read |
| host_size | input | 2 | 0 byte, 1 word, 2/3 long |
| host_addr | input | HOST_AW | Host byte address; low ADDR_W bits used |
| host_wdata | input | 32 | Write data, right-aligned |
| host_done | output | 1 | One-cycle completion pulse |
| host_err | output | 1 | Out-of-range flag, valid with host_done |
| host_rdata | output | 32 | Read data, valid with host_done |
| reg_en | output | 1 | Register-side access strobe |
| reg_we | output | 1 | Register-side write |
| reg_addr | output | ADDR_W | Register byte address, aligned to native width |
| reg_wdata | output | 32 | Register write data, right-aligned |
| reg_rdata | input | 32 | Register read data, same cycle as reg_en |

## Verification
The bench builds the bridge with HOST_AW=12, ADDR_W=10, LIMIT=0x200 and its own WMAP. In that map consecutive groups cycle through byte, word, long and unmapped. Group 0x200 is long, and everything above it is unmapped.

With this map, every size meets every native width within the first sixteen bytes, and the one-byte step past the legal limit can be reached. A 12-bit host address reaches offsets whose upper bits must be discarded.

The bench's register file is a byte array that serves the register port. Expected data comes from a plain big-endian byte view of it.

// File: rtl/rbb_pkg.sv
package rbb_pkg;

    typedef enum logic [1:0] {
        NW_NONE = 2'd0,
        NW_BYTE = 2'd1,
        NW_WORD = 2'd2,
        NW_LONG = 2'd3
    } nwidth_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SPLIT  = 3'd1,
        ST_FETCH  = 3'd2,
        ST_MERGE  = 3'd3,
        ST_FINISH = 3'd4
    } seq_state_e;

    localparam int unsigned DEF_AW     = 10;
    localparam int unsigned DEF_GROUPS = 1 << (DEF_AW - 2);

    // Host size code to byte count: 0 byte, 1 word, 2/3 long.
    function automatic logic [2:0] size_bytes(input logic [1:0] sz);
        case (sz)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [2:0] native_bytes(input nwidth_e w);
        case (w)
            NW_BYTE: return 3'd1;
            NW_WORD: return 3'd2;
            NW_LONG: return 3'd4;
            default: return 3'd0;
        endcase
    endfunction

    function automatic logic [31:0] lane_mask(input logic [2:0] nb);
        case (nb)
            3'd1:    return 32'h0000_00FF;
            3'd2:    return 32'h0000_FFFF;
            3'd4:    return 32'hFFFF_FFFF;
            default: return 32'h0000_0000;
        endcase
    endfunction

    // Default width map: bytes low, then words, then longs, bytes up to
    // and including the group at 0x200, unmapped above.
    function automatic logic [2*DEF_GROUPS-1:0] default_map();
        logic [2*DEF_GROUPS-1:0] m;
        m = '0;
        for (int g = 0; g < int'(DEF_GROUPS); g++) begin
            nwidth_e c;
            if (g < 16)       c = NW_BYTE;
            else if (g < 32)  c = NW_WORD;
            else if (g < 64)  c = NW_LONG;
            else if (g <= 128) c = NW_BYTE;
            else              c = NW_NONE;
            m[2*g +: 2] = c;
        end
        return m;
    endfunction

endpackage

// File: rtl/rbb_width_lut.sv
module rbb_width_lut
    import rbb_pkg::*;
#(
    parameter int unsigned ADDR_W = DEF_AW,
    parameter logic [(2 << (ADDR_W - 2))-1:0] WMAP = default_map()
) (
    input  logic [ADDR_W-3:0] group_idx,
    output logic [2:0]        nbytes
);
    localparam int unsigned IDX_W = ADDR_W - 1;

    logic [IDX_W-1:0] bit_pos;
    nwidth_e          code;

    assign bit_pos = {group_idx, 1'b0};
    assign code    = nwidth_e'(WMAP[bit_pos +: 2]);
    assign nbytes  = native_bytes(code);

endmodule

// File: rtl/rbb_lane_unit.sv
module rbb_lane_unit
    import rbb_pkg::*;
(
    input  logic [2:0]  acc_bytes,
    input  logic [2:0]  nat_bytes,
    input  logic [1:0]  pos,
    input  logic [1:0]  step,
    input  logic [2:0]  nsteps,
    input  logic [31:0] wdata,
    input  logic [31:0] fetch_src,
    input  logic [31:0] hold,
    input  logic [31:0] acc,
    output logic [31:0] extract_val,
    output logic [31:0] merged_val,
    output logic [31:0] chunk_val,
    output logic [31:0] acc_next
);
    logic [31:0] m_acc;
    logic [31:0] m_nat;
    logic [2:0]  gap;
    logic [5:0]  nshift;
    logic [2:0]  rem;
    logic [2:0]  units;
    logic [5:0]  cshift;
    logic [5:0]  ashift;

    assign m_acc = lane_mask(acc_bytes);
    assign m_nat = lane_mask(nat_bytes);

    // Big-endian: position 0 is the most significant byte of the register.
    assign gap    = nat_bytes - acc_bytes - {1'b0, pos};
    assign nshift = {gap, 3'b000};

    // Split piece k of n carries bits starting (n-1-k) native units up.
    assign rem    = nsteps - 3'd1 - {1'b0, step};
    assign units  = rem * nat_bytes;
    assign cshift = {units, 3'b000};
    assign ashift = {nat_bytes, 3'b000};

    always_comb begin
        extract_val = ((fetch_src & m_nat) >> nshift) & m_acc;
        merged_val  = ((hold & m_nat) & ~(m_acc << nshift))
                    | ((wdata & m_acc) << nshift);
        chunk_val   = (wdata >> cshift) & m_nat;
        if (nat_bytes == 3'd4)
            acc_next = fetch_src;
        else
            acc_next = (acc << ashift) | (fetch_src & m_nat);
    end

endmodule

// File: rtl/rbb_seq.sv
module rbb_seq
    import rbb_pkg::*;
#(
    parameter int unsigned ADDR_W = DEF_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [2:0]        sb_in,
    input  logic [2:0]        wb_in,
    input  logic [ADDR_W-1:0] off_in,
    input  logic              out_of_range,
    input  logic [31:0]       wdata_in,
    input  logic [31:0]       reg_rdata,
    input  logic [31:0]       extract_val,
    input  logic [31:0]       merged_val,
    input  logic [31:0]       chunk_val,
    input  logic [31:0]       acc_next,
    output logic [2:0]        sb_o,
    output logic [2:0]        wb_o,
    output logic [1:0]        pos_o,
    output logic [1:0]        step_o,
    output logic [2:0]        nsteps_o,
    output logic [31:0]       wd_o,
    output logic [31:0]       hold_o,
    output logic [31:0]       acc_o,
    output logic              host_done,
    output logic              host_err,
    output logic [31:0]       host_rdata,
    output logic              reg_en,
    output logic              reg_we,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [31:0]       reg_wdata
);
    seq_state_e        state_q, state_d;
    logic [ADDR_W-1:0] off_q;
    logic              we_q;
    logic              err_q;
    logic [2:0]        sb_q;
    logic [2:0]        wb_q;
    logic [31:0]       wd_q;
    logic [31:0]       hold_q;
    logic [31:0]       acc_q;
    logic [1:0]        k_q;
    logic [2:0]        n_q;
    logic [2:0]        cnt_q;
    logic [2:0]        n_start;
    logic [2:0]        wb_m1;
    logic [ADDR_W-1:0] nat_base;
    logic [ADDR_W-1:0] split_addr;
    logic              take;

    assign take = (state_q == ST_IDLE) && host_req;

    // Number of split pieces for sizes at least the native width.
    always_comb begin
        if (sb_in == wb_in)                          n_start = 3'd1;
        else if (sb_in == 3'd4 && wb_in == 3'd1)     n_start = 3'd4;
        else                                         n_start = 3'd2;
    end

    assign wb_m1      = wb_q - 3'd1;
    assign nat_base   = off_q & ~ADDR_W'(wb_m1);
    assign split_addr = off_q + ADDR_W'({1'b0, k_q} * wb_q);

    assign sb_o     = sb_q;
    assign wb_o     = wb_q;
    assign pos_o    = off_q[1:0] & wb_m1[1:0];
    assign step_o   = k_q;
    assign nsteps_o = n_q;
    assign wd_o     = wd_q;
    assign hold_o   = hold_q;
    assign acc_o    = acc_q;

    // Next state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (host_req) begin
                    if (out_of_range || wb_in == 3'd0) state_d = ST_FINISH;
                    else if (sb_in < wb_in)            state_d = ST_FETCH;
                    else                               state_d = ST_SPLIT;
                end
            end
            ST_SPLIT:  if ({1'b0, k_q} == n_q - 3'd1) state_d = ST_FINISH;
            ST_FETCH:  state_d = we_q ? ST_MERGE : ST_FINISH;
            ST_MERGE:  state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Captured request and working registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_q  <= '0;
            we_q   <= 1'b0;
            err_q  <= 1'b0;
            sb_q   <= 3'd1;
            wb_q   <= 3'd1;
            wd_q   <= '0;
            hold_q <= '0;
            acc_q  <= '0;
            k_q    <= '0;
            n_q    <= 3'd1;
            cnt_q  <= '0;
        end else begin
            if (take) begin
                off_q  <= off_in;
                we_q   <= host_we;
                err_q  <= out_of_range;
                sb_q   <= sb_in;
                wb_q   <= wb_in;
                wd_q   <= wdata_in;
                acc_q  <= '0;
                k_q    <= '0;
                n_q    <= n_start;
                cnt_q  <= '0;
            end else begin
                if (reg_en) cnt_q <= cnt_q + 3'd1;
                if (state_q == ST_SPLIT) begin
                    k_q <= k_q + 2'd1;
                    if (!we_q) acc_q <= acc_next;
                end
                if (state_q == ST_FETCH) begin
                    hold_q <= reg_rdata;
                    if (!we_q) acc_q <= extract_val;
                end
            end
        end
    end

    // Outputs by state.
    always_comb begin
        host_done  = 1'b0;
        host_err   = 1'b0;
        host_rdata = '0;
        reg_en     = 1'b0;
        reg_we     = 1'b0;
        reg_addr   = '0;
        reg_wdata  = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_SPLIT: begin
                reg_en    = 1'b1;
                reg_we    = we_q;
                reg_addr  = split_addr;
                reg_wdata = we_q ? chunk_val : 32'd0;
            end
            ST_FETCH: begin
                reg_en   = 1'b1;
                reg_addr = nat_base;
            end
            ST_MERGE: begin
                reg_en    = 1'b1;
                reg_we    = 1'b1;
                reg_addr  = nat_base;
                reg_wdata = merged_val;
            end
            ST_FINISH: begin
                host_done  = 1'b1;
                host_err   = err_q;
                host_rdata = acc_q;
            end
            default: ;
        endcase
    end

    // R2: out-of-range request completes next cycle with the flag, no register cycle.
    a_r2_range_err: assert property (@(posedge clk) disable iff (!rst_n)
        (take && out_of_range) |=> (host_done && host_err && !reg_en));

    // R4: unmapped space is silent and reads zero.
    a_r4_hole_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !out_of_range && wb_in == 3'd0)
        |=> (host_done && !host_err && host_rdata == 32'd0 && !reg_en));

    // R7: write-back follows a read of the same register.
    a_r7_merge_after_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MERGE) |-> ($past(reg_en && !reg_we) && $stable(reg_addr)));

    // R8/R9: split pieces walk upward by one native width per cycle.
    a_r9_split_walk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SPLIT && $past(state_q) == ST_SPLIT)
        |-> (reg_addr == $past(reg_addr) + ADDR_W'(wb_q)));

    // R10: done is a single-cycle pulse.
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        host_done |=> !host_done);

    // R10: never more than four register cycles per host access.
    a_r10_max_four: assert property (@(posedge clk) disable iff (!rst_n)
        host_done |-> (cnt_q <= 3'd4));

    // R12: captured request is frozen while busy.
    a_r12_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> (off_q == $past(off_q) && we_q == $past(we_q)
                                  && wd_q == $past(wd_q)));

endmodule

// File: rtl/regbus_width_bridge.sv
module regbus_width_bridge
    import rbb_pkg::*;
#(
    parameter int unsigned HOST_AW = 16,
    parameter int unsigned ADDR_W  = DEF_AW,
    parameter int unsigned LIMIT   = 32'h200,
    parameter logic [(2 << (ADDR_W - 2))-1:0] WMAP = default_map()
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_req,
    input  logic               host_we,
    input  logic [1:0]         host_size,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [31:0]        host_wdata,
    output logic               host_done,
    output logic               host_err,
    output logic [31:0]        host_rdata,
    output logic               reg_en,
    output logic               reg_we,
    output logic [ADDR_W-1:0]  reg_addr,
    output logic [31:0]        reg_wdata,
    input  logic [31:0]        reg_rdata
);
    logic [ADDR_W-1:0] off_raw;
    logic [ADDR_W-1:0] off_al;
    logic [2:0]        sb_in;
    logic [2:0]        wb_in;
    logic              out_of_range;

    logic [2:0]  sb_q, wb_q, nsteps;
    logic [1:0]  pos, step;
    logic [31:0] wd_q, hold_q, acc_q;
    logic [31:0] extract_val, merged_val, chunk_val, acc_next;

    assign off_raw = host_addr[ADDR_W-1:0];

    generate
        if (HOST_AW > ADDR_W) begin : g_drop_hi
            logic unused_hi;
            assign unused_hi = ^host_addr[HOST_AW-1:ADDR_W];
        end
    endgenerate

    assign sb_in  = size_bytes(host_size);
    assign off_al = {off_raw[ADDR_W-1:2],
                     off_raw[1] & (sb_in != 3'd4),
                     off_raw[0] & (sb_in == 3'd1)};
    assign out_of_range = 32'(off_al) > LIMIT;

    rbb_width_lut #(
        .ADDR_W (ADDR_W),
        .WMAP   (WMAP)
    ) u_lut (
        .group_idx (off_al[ADDR_W-1:2]),
        .nbytes    (wb_in)
    );

    rbb_lane_unit u_lane (
        .acc_bytes   (sb_q),
        .nat_bytes   (wb_q),
        .pos         (pos),
        .step        (step),
        .nsteps      (nsteps),
        .wdata       (wd_q),
        .fetch_src   (reg_rdata),
        .hold        (hold_q),
        .acc         (acc_q),
        .extract_val (extract_val),
        .merged_val  (merged_val),
        .chunk_val   (chunk_val),
        .acc_next    (acc_next)
    );

    rbb_seq #(
        .ADDR_W (ADDR_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_req     (host_req),
        .host_we      (host_we),
        .sb_in        (sb_in),
        .wb_in        (wb_in),
        .off_in       (off_al),
        .out_of_range (out_of_range),
        .wdata_in     (host_wdata),
        .reg_rdata    (reg_rdata),
        .extract_val  (extract_val),
        .merged_val   (merged_val),
        .chunk_val    (chunk_val),
        .acc_next     (acc_next),
        .sb_o         (sb_q),
        .wb_o         (wb_q),
        .pos_o        (pos),
        .step_o       (step),
        .nsteps_o     (nsteps),
        .wd_o         (wd_q),
        .hold_o       (hold_q),
        .acc_o        (acc_q),
        .host_done    (host_done),
        .host_err     (host_err),
        .host_rdata   (host_rdata),
        .reg_en       (reg_en),
        .reg_we       (reg_we),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata)
    );

endmodule

// File: tb/regbus_width_bridge_tb_top.sv
module regbus_width_bridge_tb_top;

    // Bench map: group g -> bytes. g%4: 0 byte, 1 word, 2 long, 3 unmapped;
    // group 128 (0x200) long, above it unmapped.
    function automatic int tb_nb(input int g);
        if (g == 128) return 4;
        if (g > 128)  return 0;
        case (g % 4)
            0: return 1;
            1: return 2;
            2: return 4;
            default: return 0;
        endcase
    endfunction

    function automatic logic [511:0] tb_map();
        logic [511:0] m;
        m = '0;
        for (int g = 0; g < 256; g++) begin
            int nb;
            nb = tb_nb(g);
            m[2*g +: 2] = (nb == 0) ? 2'd0 : (nb == 1) ? 2'd1 : (nb == 2) ? 2'd2 : 2'd3;
        end
        return m;
    endfunction

    localparam logic [511:0] TB_MAP = tb_map();

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic        host_we = 1'b0;
    logic [1:0]  host_size = 2'd0;
    logic [11:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic        host_done, host_err;
    logic [31:0] host_rdata;
    logic        reg_en, reg_we;
    logic [9:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;

    int checks = 0;
    int errors = 0;

    logic [7:0] mem [0:1023];

    always #5 clk = ~clk;

    regbus_width_bridge #(
        .HOST_AW (12),
        .ADDR_W  (10),
        .LIMIT   (32'h200),
        .WMAP    (TB_MAP)
    ) dut_i (
        .clk (clk), .rst_n (rst_n),
        .host_req (host_req), .host_we (host_we), .host_size (host_size),
        .host_addr (host_addr), .host_wdata (host_wdata),
        .host_done (host_done), .host_err (host_err), .host_rdata (host_rdata),
        .reg_en (reg_en), .reg_we (reg_we), .reg_addr (reg_addr),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata)
    );

    // Register file behind the bridge: big-endian bytes of native width.
    always_comb begin
        int nb;
        reg_rdata = '0;
        nb = tb_nb(int'(reg_addr) >> 2);
        for (int i = 0; i < 4; i++)
            if (i < nb) reg_rdata = (reg_rdata << 8) | 32'(mem[(int'(reg_addr) + i) & 1023]);
    end

    always @(posedge clk) begin
        if (rst_n && reg_en && reg_we) begin
            int nb;
            nb = tb_nb(int'(reg_addr) >> 2);
            for (int i = 0; i < 4; i++)
                if (i < nb) mem[(int'(reg_addr) + i) & 1023] <= 8'(reg_wdata >> ((nb - 1 - i) * 8));
        end
    end

    task automatic chk(input string tag, input bit ok, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] msk(input int w);
        return (w == 4) ? 32'hFFFF_FFFF : ((32'h1 << (w * 8)) - 32'h1);
    endfunction

    // One host access with reference expectations, checked every cycle.
    task automatic run(input string tag, input int sz, input int addr, input bit we,
                       input logic [31:0] wd, input bit poke);
        int sb, o, w, gb, n;
        bit err;
        bit qwe[$];
        int qad[$];
        logic [31:0] qdt[$];
        logic [31:0] exp_rd;
        logic [7:0] expg [0:3];
        sb  = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        o   = (addr & 'h3FF) & ~(sb - 1);
        err = (o > 'h200);
        w   = err ? 0 : tb_nb(o >> 2);
        gb  = o & ~3;
        exp_rd = '0;
        for (int i = 0; i < 4; i++) expg[i] = mem[gb + i];
        if (we && w != 0)
            for (int i = 0; i < sb; i++) expg[(o - gb) + i] = 8'(wd >> ((sb - 1 - i) * 8));
        if (!we && w != 0)
            for (int i = 0; i < sb; i++) exp_rd = (exp_rd << 8) | 32'(mem[o + i]);
        if (w != 0) begin
            if (sb >= w) begin
                n = sb / w;
                for (int k = 0; k < n; k++) begin
                    qwe.push_back(we);
                    qad.push_back(o + k * w);
                    qdt.push_back((wd >> ((n - 1 - k) * w * 8)) & msk(w));
                end
            end else begin
                int base;
                logic [31:0] mv;
                base = o & ~(w - 1);
                qwe.push_back(1'b0); qad.push_back(base); qdt.push_back('0);
                if (we) begin
                    mv = '0;
                    for (int i = 0; i < w; i++) mv = (mv << 8) | 32'(expg[(base - gb) + i]);
                    qwe.push_back(1'b1); qad.push_back(base); qdt.push_back(mv);
                end
            end
        end
        n = qad.size();
        @(negedge clk);
        host_req = 1'b1; host_we = we; host_size = 2'(sz);
        host_addr = 12'(addr); host_wdata = wd;
        for (int c = 1; c <= n + 1; c++) begin
            @(negedge clk);
            if (!poke || c == n + 1) host_req = 1'b0;
            else begin
                host_addr = 12'(addr ^ 'h0F4); host_size = 2'd2;
                host_we = ~we; host_wdata = ~wd;
            end
            if (c <= n) begin
                chk("R10", !host_done, "done early", 32'(host_done), 32'd0);
                chk(tag, reg_en, "reg_en", 32'(reg_en), 32'd1);
                chk(tag, reg_we == qwe[c-1], "reg_we", 32'(reg_we), 32'(qwe[c-1]));
                chk(tag, int'(reg_addr) == qad[c-1], "reg_addr", 32'(reg_addr), 32'(qad[c-1]));
                if (qwe[c-1])
                    chk(tag, reg_wdata == qdt[c-1], "reg_wdata", reg_wdata, qdt[c-1]);
            end else begin
                chk("R10", host_done && !reg_en, "done/reg_en at end",
                    {30'd0, host_done, reg_en}, 32'h2);
                chk(tag, host_err == err, "err", 32'(host_err), 32'(err));
                chk(tag, host_rdata == exp_rd, "rdata", host_rdata, exp_rd);
            end
        end
        @(negedge clk);
        chk(poke ? "R12" : "R10", !host_done && !reg_en, "idle after done",
            {30'd0, host_done, reg_en}, 32'd0);
        for (int i = 0; i < 4; i++)
            chk(tag, mem[gb + i] == expg[i], "register bytes", 32'(mem[gb + i]), 32'(expg[i]));
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 8'((i * 7 + 3) ^ (i >> 3));
        repeat (3) @(negedge clk);
        chk("R1", !host_done && !host_err && !reg_en, "reset outputs",
            {29'd0, host_done, host_err, reg_en}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", !host_done && !reg_en, "after reset", {30'd0, host_done, reg_en}, 32'd0);

        run("R5",  2, 'h008, 1'b0, 32'h0, 1'b0);               // long on long
        run("R3",  0, 'h000, 1'b0, 32'h0, 1'b0);               // byte on byte
        run("R5",  1, 'h014, 1'b1, 32'h0000_BEEF, 1'b0);       // word on word
        run("R6",  0, 'h004, 1'b0, 32'h0, 1'b0);               // high byte of word
        run("R6",  0, 'h005, 1'b0, 32'h0, 1'b0);               // low byte of word
        run("R6",  0, 'h00B, 1'b0, 32'h0, 1'b0);               // lowest byte of long
        run("R6",  1, 'h008, 1'b0, 32'h0, 1'b0);               // upper half of long
        run("R7",  0, 'h005, 1'b1, 32'h0000_00A5, 1'b0);
        run("R7",  1, 'h00A, 1'b1, 32'h0000_1234, 1'b0);
        run("R7",  0, 'h009, 1'b1, 32'h0000_005A, 1'b0);
        run("R8",  1, 'h000, 1'b0, 32'h0, 1'b0);
        run("R8",  1, 'h002, 1'b1, 32'h0000_C3D4, 1'b0);
        run("R9",  2, 'h004, 1'b0, 32'h0, 1'b0);
        run("R9",  2, 'h014, 1'b1, 32'h8765_4321, 1'b0);
        run("R9",  2, 'h010, 1'b0, 32'h0, 1'b0);
        run("R9",  2, 'h020, 1'b1, 32'hCAFE_F00D, 1'b0);
        run("R4",  2, 'h00C, 1'b0, 32'h0, 1'b0);
        run("R4",  0, 'h00D, 1'b1, 32'h0000_0077, 1'b0);
        run("R2",  2, 'h200, 1'b1, 32'h1122_3344, 1'b0);
        run("R2",  2, 'h200, 1'b0, 32'h0, 1'b0);
        run("R2",  2, 'h204, 1'b0, 32'h0, 1'b0);
        run("R2",  0, 'h201, 1'b0, 32'h0, 1'b0);
        run("R2",  1, 'h3FE, 1'b1, 32'h0000_FFFF, 1'b0);
        run("R2",  2, 'h408, 1'b0, 32'h0, 1'b0);               // upper bits dropped
        run("R11", 2, 'h00A, 1'b0, 32'h0, 1'b0);
        run("R11", 1, 'h015, 1'b0, 32'h0, 1'b0);
        run("R11", 2, 'h013, 1'b1, 32'h0BAD_CAFE, 1'b0);
        run("R12", 2, 'h010, 1'b1, 32'h1357_9BDF, 1'b1);
        run("R12", 0, 'h00B, 1'b1, 32'h0000_00E1, 1'b1);
        run("R12", 1, 'h000, 1'b0, 32'h0, 1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule